// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block rules on a single memory access that an address-translation stage has already resolved to a descriptor. It takes the two-bit access value that the domain control register holds for the descriptor's domain, together with the descriptor's two-bit permission field. It also takes the privilege of the request and the two global protection control bits. From these it computes an access level: none, read-only or read/write. The access is granted only when that level exceeds the write flag. The level, the grant and the fault decision are combinational, so the requesting pipeline can act on them in the same cycle.

A registered reporting stage sits behind the decision. It is a three-state machine: `ST_IDLE`, `ST_DATA_ABT` and `ST_FETCH_ABT`. On every clock edge the machine moves to `ST_DATA_ABT` when the cycle holds a reportable data-side fault. It moves to `ST_FETCH_ABT` when the cycle holds a reportable instruction-fetch fault. In every other case it returns to `ST_IDLE`. These transitions are taken from any state, so faults on consecutive cycles keep the machine in an abort state. The `data_abort` strobe is high while the machine is in `ST_DATA_ABT`, and `prefetch_abort` is high while it is in `ST_FETCH_ABT`. On the edge that enters `ST_DATA_ABT`, the fault address and fault status registers are loaded. A request flagged as a probe gets the decision without any side effect.

Top module: `apchk_top`

## Requirements
- R1: `acc_level` encodes 0 = no access, 1 = read-only, 2 = read/write. With `req_valid` high, `granted` is 1 exactly when `acc_level` is greater than `is_write` (0 for a read, 1 for a write), and `fault` is the inverse of `granted`. With `req_valid` low, both `granted` and `fault` are 0.
- R2: A domain value of 0 gives level 0 and a domain value of 3 gives level 2, whatever the permission field, privilege or protection bits. A domain value of 1 applies the permission decode.
- R3: Domain value 2 is reserved. It raises `rsvd_dom_err` and gives level 0. The flag is low for every other domain value.
- R4: For a client domain (value 1) with permission 0, the level depends on the protection bits `sys_prot` and `rom_prot`. With both clear the level is 0. With only `sys_prot` set, a privileged access gets 1 and a user access gets 0. With only `rom_prot` set, both get 1.
- R5: For a client domain, permission 1 gives 2 to a privileged access and 0 to a user access. Permission 2 gives 2 to a privileged access and 1 to a user access. Permission 3 gives 2 to both.
- R6: An access is treated as user when `cpu_user` is high or when `force_user` is high.
- R7: For a client domain with permission 0 and both protection bits set, the level is 0 and `ap_unpred` is raised. `ap_unpred` is low in every other case.
- R8: A data-side fault (`fault` high, `is_fetch` low, `no_exc` low) loads `far` with `vaddr` and `fsr` with {`domain`, code} at the next clock edge, where `domain` occupies bits [7:4] and the code bits [3:0]. The code is 4'h9 for a domain fault on a section, 4'hB for a domain fault on a page, 4'hD for a permission fault on a section and 4'hF for a permission fault on a page. A domain fault is one with domain value 0 or 2. `is_page` = 1 selects page.
- R9: `data_abort` is high for the cycle after each data-side fault edge. `prefetch_abort` is high for the cycle after each instruction-fetch fault edge. The two are never high together, and neither is high after a cycle without such a fault.
- R10: An instruction-fetch fault leaves `fsr` and `far` unchanged.
- R11: A request with `no_exc` high changes neither `fsr` nor `far` and produces no abort strobe. The combinational decision is still returned.
- R12: After reset, `fsr` and `far` are zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| dom_av | input | 2 | Domain access value for the descriptor's domain |
| ap | input | 2 | Access permission field from the descriptor |
| cpu_user | input | 1 | Processor is in user mode |
| force_user | input | 1 | Request asks for user-level checking |
| sys_prot | input | 1 | System protection control bit |
| rom_prot | input | 1 | ROM protection control bit |
| is_write | input | 1 | Access is a write |
| is_fetch | input | 1 | Access is an instruction fetch |
| no_exc | input | 1 | Probe only: no register update, no abort |
| is_page | input | 1 | Descriptor is a page (1) or section (0) |
| domain | input | 4 | Domain number of the descriptor |
| vaddr | input | 32 | Virtual address of the access |
| acc_level | output | 2 | Access level 0/1/2 |
| granted | output | 1 | Access allowed |
| fault | output | 1 | Access denied |
| rsvd_dom_err | output | 1 | Reserved domain value seen |
| ap_unpred | output | 1 | Unpredictable protection-bit combination seen |
| fsr | output | 8 | Fault status register |
| far | output | 32 | Fault address register |
| data_abort | output | 1 | Data abort strobe |
| prefetch_abort | output | 1 | Prefetch abort strobe |

## Verification
A machine left in the wrong state shows up at the ports one clock after the faulting request. The evidence is an abort strobe that is missing, one that stays high through an idle cycle, or the wrong strobe kind. A stale or corrupted fault register is caught on the cycle after every request, because the bench compares `fsr` and `far` against its own model after each edge. This includes fetch faults and probes, where a correct design must hold them. A decode error in the level table appears immediately on `acc_level` and `granted` in the same cycle as the request.

// File: rtl/apchk_pkg.sv
`timescale 1ns/1ps
package apchk_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_RO   = 2'd1,
        LVL_RW   = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        DOM_DENY   = 2'd0,
        DOM_CLIENT = 2'd1,
        DOM_RSVD   = 2'd2,
        DOM_MGR    = 2'd3
    } dom_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DATA_ABT  = 2'd1,
        ST_FETCH_ABT = 2'd2
    } abt_state_e;

    localparam int FC_W = 4;

    localparam logic [FC_W-1:0] FC_DOM_SEC   = 4'h9;
    localparam logic [FC_W-1:0] FC_DOM_PAGE  = 4'hB;
    localparam logic [FC_W-1:0] FC_PERM_SEC  = 4'hD;
    localparam logic [FC_W-1:0] FC_PERM_PAGE = 4'hF;

endpackage

// File: rtl/apchk_ap_decode.sv
`timescale 1ns/1ps
module apchk_ap_decode
    import apchk_pkg::*;
(
    input  logic [1:0] ap,
    input  logic       user,
    input  logic       sys_prot,
    input  logic       rom_prot,
    output lvl_e       lvl,
    output logic       unpred
);

    always_comb begin
        lvl    = LVL_NONE;
        unpred = 1'b0;
        unique case (ap)
            2'd0: begin
                unique case ({sys_prot, rom_prot})
                    2'b00: lvl = LVL_NONE;
                    2'b10: lvl = user ? LVL_NONE : LVL_RO;
                    2'b01: lvl = LVL_RO;
                    default: begin
                        lvl    = LVL_NONE;
                        unpred = 1'b1;
                    end
                endcase
            end
            2'd1: lvl = user ? LVL_NONE : LVL_RW;
            2'd2: lvl = user ? LVL_RO : LVL_RW;
            default: lvl = LVL_RW;
        endcase
    end

endmodule

// File: rtl/apchk_dom_gate.sv
`timescale 1ns/1ps
module apchk_dom_gate
    import apchk_pkg::*;
(
    input  logic [1:0] dom_av,
    input  lvl_e       ap_lvl,
    input  logic       ap_unpred,
    output lvl_e       lvl,
    output logic       rsvd_err,
    output logic       unpred_out,
    output logic       dom_deny
);

    dom_e dv;
    assign dv = dom_e'(dom_av);

    always_comb begin
        lvl        = LVL_NONE;
        rsvd_err   = 1'b0;
        unpred_out = 1'b0;
        dom_deny   = 1'b0;
        unique case (dv)
            DOM_DENY: begin
                dom_deny = 1'b1;
            end
            DOM_CLIENT: begin
                lvl        = ap_lvl;
                unpred_out = ap_unpred;
            end
            DOM_RSVD: begin
                rsvd_err = 1'b1;
                dom_deny = 1'b1;
            end
            default: begin
                lvl = LVL_RW;
            end
        endcase
    end

endmodule

// File: rtl/apchk_fault_fsm.sv
`timescale 1ns/1ps
module apchk_fault_fsm
    import apchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 4,
    localparam int FSR_W = DOM_W + FC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              report_data,
    input  logic              report_fetch,
    input  logic [DOM_W-1:0]  domain,
    input  logic [FC_W-1:0]   code,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [FSR_W-1:0]  fsr,
    output logic [ADDR_W-1:0] far,
    output logic              data_abort,
    output logic              prefetch_abort
);

    abt_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (report_data) begin
            state_d = ST_DATA_ABT;
        end else if (report_fetch) begin
            state_d = ST_FETCH_ABT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr <= '0;
            far <= '0;
        end else if (report_data) begin
            fsr <= {domain, code};
            far <= vaddr;
        end
    end

    always_comb begin
        data_abort     = 1'b0;
        prefetch_abort = 1'b0;
        unique case (state_q)
            ST_DATA_ABT:  data_abort     = 1'b1;
            ST_FETCH_ABT: prefetch_abort = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/apchk_top.sv
`timescale 1ns/1ps
module apchk_top
    import apchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 4,
    localparam int FSR_W = DOM_W + FC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        dom_av,
    input  logic [1:0]        ap,
    input  logic              cpu_user,
    input  logic              force_user,
    input  logic              sys_prot,
    input  logic              rom_prot,
    input  logic              is_write,
    input  logic              is_fetch,
    input  logic              no_exc,
    input  logic              is_page,
    input  logic [DOM_W-1:0]  domain,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [1:0]        acc_level,
    output logic              granted,
    output logic              fault,
    output logic              rsvd_dom_err,
    output logic              ap_unpred,
    output logic [FSR_W-1:0]  fsr,
    output logic [ADDR_W-1:0] far,
    output logic              data_abort,
    output logic              prefetch_abort
);

    logic            user_eff;
    lvl_e            ap_lvl;
    logic            ap_bad;
    lvl_e            fin_lvl;
    logic            dom_deny;
    logic [FC_W-1:0] code;
    logic            reportable;

    assign user_eff = cpu_user | force_user;

    apchk_ap_decode u_ap (
        .ap       (ap),
        .user     (user_eff),
        .sys_prot (sys_prot),
        .rom_prot (rom_prot),
        .lvl      (ap_lvl),
        .unpred   (ap_bad)
    );

    apchk_dom_gate u_dom (
        .dom_av     (dom_av),
        .ap_lvl     (ap_lvl),
        .ap_unpred  (ap_bad),
        .lvl        (fin_lvl),
        .rsvd_err   (rsvd_dom_err),
        .unpred_out (ap_unpred),
        .dom_deny   (dom_deny)
    );

    assign acc_level = fin_lvl;
    assign granted   = req_valid && (fin_lvl > {1'b0, is_write});
    assign fault     = req_valid && !granted;

    always_comb begin
        unique case ({dom_deny, is_page})
            2'b10:   code = FC_DOM_SEC;
            2'b11:   code = FC_DOM_PAGE;
            2'b00:   code = FC_PERM_SEC;
            default: code = FC_PERM_PAGE;
        endcase
    end

    assign reportable = fault && !no_exc;

    apchk_fault_fsm #(
        .ADDR_W (ADDR_W),
        .DOM_W  (DOM_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .report_data    (reportable && !is_fetch),
        .report_fetch   (reportable && is_fetch),
        .domain         (domain),
        .code           (code),
        .vaddr          (vaddr),
        .fsr            (fsr),
        .far            (far),
        .data_abort     (data_abort),
        .prefetch_abort (prefetch_abort)
    );

endmodule

// File: rtl/apchk_sva.sv
`timescale 1ns/1ps
module apchk_sva #(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 4,
    localparam int FSR_W = DOM_W + 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        dom_av,
    input logic              is_write,
    input logic              is_fetch,
    input logic              no_exc,
    input logic [ADDR_W-1:0] vaddr,
    input logic [1:0]        acc_level,
    input logic              granted,
    input logic              fault,
    input logic              rsvd_dom_err,
    input logic [FSR_W-1:0]  fsr,
    input logic [ADDR_W-1:0] far,
    input logic              data_abort,
    input logic              prefetch_abort
);

    // R1
    grant_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> (req_valid && (acc_level > {1'b0, is_write}) && !fault));

    // R2
    mgr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_av == 2'd3) |-> (acc_level == 2'd2));

    // R2
    deny_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_av == 2'd0) |-> (acc_level == 2'd0));

    // R3
    rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_av == 2'd2) |-> (rsvd_dom_err && acc_level == 2'd0));

    // R8
    far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !is_fetch && !no_exc) |=> (far == $past(vaddr) && data_abort));

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && is_fetch && !no_exc) |=> (prefetch_abort && $stable(far) && $stable(fsr)));

    // R11
    probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && no_exc) |=> (!data_abort && !prefetch_abort && $stable(far) && $stable(fsr)));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_abort, prefetch_abort}));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault) |=> (!data_abort && !prefetch_abort));

endmodule

bind apchk_top apchk_sva #(
    .ADDR_W (ADDR_W),
    .DOM_W  (DOM_W)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .dom_av         (dom_av),
    .is_write       (is_write),
    .is_fetch       (is_fetch),
    .no_exc         (no_exc),
    .vaddr          (vaddr),
    .acc_level      (acc_level),
    .granted        (granted),
    .fault          (fault),
    .rsvd_dom_err   (rsvd_dom_err),
    .fsr            (fsr),
    .far            (far),
    .data_abort     (data_abort),
    .prefetch_abort (prefetch_abort)
);

// File: tb/tb_apchk_top.sv
`timescale 1ns/1ps
module tb_apchk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  dom_av = '0;
    logic [1:0]  ap = '0;
    logic        cpu_user = 1'b0;
    logic        force_user = 1'b0;
    logic        sys_prot = 1'b0;
    logic        rom_prot = 1'b0;
    logic        is_write = 1'b0;
    logic        is_fetch = 1'b0;
    logic        no_exc = 1'b0;
    logic        is_page = 1'b0;
    logic [3:0]  domain = '0;
    logic [31:0] vaddr = '0;
    logic [1:0]  acc_level;
    logic        granted, fault, rsvd_dom_err, ap_unpred;
    logic [7:0]  fsr;
    logic [31:0] far;
    logic        data_abort, prefetch_abort;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_fsr = '0;
    logic [31:0] m_far = '0;

    always #10 clk = ~clk;

    apchk_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dom_av(dom_av), .ap(ap),
        .cpu_user(cpu_user), .force_user(force_user), .sys_prot(sys_prot),
        .rom_prot(rom_prot), .is_write(is_write), .is_fetch(is_fetch),
        .no_exc(no_exc), .is_page(is_page), .domain(domain), .vaddr(vaddr),
        .acc_level(acc_level), .granted(granted), .fault(fault),
        .rsvd_dom_err(rsvd_dom_err), .ap_unpred(ap_unpred), .fsr(fsr), .far(far),
        .data_abort(data_abort), .prefetch_abort(prefetch_abort)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ap_ref(int apv, bit usr, bit s, bit r);
        case (apv)
            0: begin
                if (!s && !r) return 0;
                if (s && !r)  return usr ? 0 : 1;
                if (!s && r)  return 1;
                return 0;
            end
            1: return usr ? 0 : 2;
            2: return usr ? 1 : 2;
            default: return 2;
        endcase
    endfunction

    function automatic int lvl_ref(int dv, int apv, bit usr, bit s, bit r);
        case (dv)
            0: return 0;
            1: return ap_ref(apv, usr, s, r);
            2: return 0;
            default: return 2;
        endcase
    endfunction

    function automatic logic [3:0] code_ref(int dv, bit pg);
        bit dd = (dv == 0) || (dv == 2);
        if (dd) return pg ? 4'hB : 4'h9;
        return pg ? 4'hF : 4'hD;
    endfunction

    task automatic do_req(input bit v, input int dv, input int apv, input bit cu,
                          input bit fu, input bit s, input bit r, input bit wr,
                          input bit fe, input bit ne, input bit pg,
                          input logic [3:0] dm, input logic [31:0] va);
        int  el;
        bit  eg, ef, usr;
        @(negedge clk);
        req_valid = v; dom_av = 2'(dv); ap = 2'(apv); cpu_user = cu; force_user = fu;
        sys_prot = s; rom_prot = r; is_write = wr; is_fetch = fe; no_exc = ne;
        is_page = pg; domain = dm; vaddr = va;
        #1;
        usr = cu | fu;
        el = lvl_ref(dv, apv, usr, s, r);
        eg = v && (el > int'(wr));
        ef = v && !eg;
        // R1 R2 R4 R5 R6 level checks
        chk(acc_level == 2'(el), "R1/R2/R4/R5/R6 level", 64'(acc_level), 64'(el));
        chk(granted == eg && fault == ef, "R1 grant", {granted, fault}, {eg, ef});
        // R3
        chk(rsvd_dom_err == (dv == 2), "R3 rsvd", 64'(rsvd_dom_err), 64'(dv == 2));
        // R7
        chk(ap_unpred == (dv == 1 && apv == 0 && s && r), "R7 unpred",
            64'(ap_unpred), 64'(dv == 1 && apv == 0 && s && r));
        @(posedge clk);
        #1;
        if (ef && !ne && !fe) begin
            m_fsr = {dm, code_ref(dv, pg)};
            m_far = va;
        end
        // R9 R11 strobes
        chk(data_abort == (ef && !ne && !fe), "R9/R11 data_abort",
            64'(data_abort), 64'(ef && !ne && !fe));
        chk(prefetch_abort == (ef && !ne && fe), "R9/R11 prefetch_abort",
            64'(prefetch_abort), 64'(ef && !ne && fe));
        // R8 R10 R11 registers
        chk(fsr == m_fsr, "R8/R10/R11 fsr", 64'(fsr), 64'(m_fsr));
        chk(far == m_far, "R8/R10/R11 far", 64'(far), 64'(m_far));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk(fsr == 8'h0 && far == 32'h0, "R12 regs", {fsr, far}, 64'h0);
        chk(!data_abort && !prefetch_abort, "R12 strobes",
            {data_abort, prefetch_abort}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        do_req(1, 3, 1, 1, 0, 0, 0, 1, 0, 0, 0, 4'h2, 32'h1000_0000); // R2 manager
        do_req(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 1, 4'h5, 32'hDEAD_BEEF); // R2/R8 domain page
        do_req(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 4'hA, 32'h0000_1234); // R3 domain section
        do_req(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 4'h3, 32'h0BAD_0000); // R7 unpred, perm sec
        do_req(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 4'h1, 32'h1111_0000); // R4 S priv read ok
        do_req(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 4'h6, 32'h2222_0000); // R4 R6 forced user
        do_req(1, 1, 2, 1, 0, 0, 0, 1, 0, 0, 1, 4'h7, 32'h3333_0000); // R5 user write fault
        do_req(1, 1, 1, 1, 0, 0, 0, 0, 1, 0, 1, 4'h8, 32'h4444_0000); // R10 fetch fault
        do_req(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 4'h9, 32'h5555_0000); // R11 probe
        do_req(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 4'hC, 32'h6666_0000); // R1 idle
        do_req(1, 1, 0, 0, 0, 0, 1, 1, 0, 0, 1, 4'hD, 32'h7777_0000); // R4 R only write
        do_req(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 4'hE, 32'h8888_0000); // R4 R only read

        // constrained random
        void'($urandom(32'd20240917));
        for (int i = 0; i < 600; i++) begin
            do_req(($urandom % 10) != 0, int'($urandom % 4), int'($urandom % 4),
                   1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'(($urandom % 3) == 0), 1'(($urandom % 5) == 0),
                   1'($urandom), 4'($urandom), $urandom);
        end

        do_req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule